// File: doc/BRIEF.md
# Three-Way Intersection Light Sequencer

This block is a synchronous Moore state machine that runs the signal heads at an intersection where two through streets (A, running north-south, and B, running east-west) meet a lightly used side street C. It drives five signal heads: A northbound-facing (cars arriving from the north), A from the south, B from the east, B from the west, and C. The head facing traffic from the north on A also carries a left-turn arrow. This gives a protected turn in every cycle, and the through-green for that direction stays lit alongside it.

The block does not count time itself. An external interval timer is restarted by a one-cycle strobe from the block. That timer later reports a short-interval flag and a long-interval flag. A sensor in street C requests the C phase. When no car waits, the C phase is skipped. When the sensor drops, or when one long interval has passed, C green ends.

Top module: `tri_way_signal_ctrl`

## Requirements
- R1: While `rst_n` is low, the block shows the arrow-green phase and holds `tmr_restart` high. After reset is released, the arrow-green phase is kept until a short-interval flag arrives.
- R2: Each of the five heads lights exactly one of its green, yellow and red lamps. The arrow shows exactly one of `arw_grn`, `arw_yel` and `arw_off`.
- R3: The phases follow a fixed order. The order is arrow green, then arrow yellow, then A green, then A yellow, then B green, then B yellow. After that comes C green and C yellow if the C phase is requested. The cycle then returns to arrow green.
- R4: In both arrow phases, A-north shows green and the other four heads show red.
- R5: Arrow green, arrow yellow and every yellow phase leave on `tmr_short` alone. `tmr_long` has no effect in them.
- R6: The A green and B green phases leave on `tmr_long` alone. `tmr_short` has no effect in them.
- R7: B yellow moves on when `tmr_short` is high. If `car_wait` is high in that same cycle, it goes to C green; if not, it goes to arrow green. `car_wait` has no effect in any phase other than B yellow and C green.
- R8: C green goes to C yellow in the first cycle in which `car_wait` is low or `tmr_long` is high. C yellow then goes back to arrow green on `tmr_short`.
- R9: `tmr_restart` is high for exactly the first cycle of every new phase and low in all other cycles after reset.
- R10: At most one street group shows a non-red lamp at any time. The groups are A (both A heads and the arrow), B (both B heads) and C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| car_wait | input | 1 | C-street sensor, high when a car waits |
| tmr_long | input | 1 | Long interval elapsed since last restart |
| tmr_short | input | 1 | Short interval elapsed since last restart |
| tmr_restart | output | 1 | One-cycle strobe restarting the external timer |
| an_grn | output | 1 | A from north, green |
| an_yel | output | 1 | A from north, yellow |
| an_red | output | 1 | A from north, red |
| arw_grn | output | 1 | Left-turn arrow green |
| arw_yel | output | 1 | Left-turn arrow yellow |
| arw_off | output | 1 | Left-turn arrow dark |
| as_grn | output | 1 | A from south, green |
| as_yel | output | 1 | A from south, yellow |
| as_red | output | 1 | A from south, red |
| be_grn | output | 1 | B from east, green |
| be_yel | output | 1 | B from east, yellow |
| be_red | output | 1 | B from east, red |
| bw_grn | output | 1 | B from west, green |
| bw_yel | output | 1 | B from west, yellow |
| bw_red | output | 1 | B from west, red |
| c_grn | output | 1 | C street, green |
| c_yel | output | 1 | C street, yellow |
| c_red | output | 1 | C street, red |

## Verification
The block samples its inputs on a rising edge and moves to its new phase on that same edge. The lamp outputs are decoded from the phase register only, so every lamp result is due one edge after the stimulus. The restart strobe is registered beside the phase, so it rises on the same edge. The bench drives each stimulus on a falling edge and queues the expected lamps and strobe once the next rising edge has passed. A monitor compares them on the following falling edge, half a period after they settle. Because no output depends on the inputs through logic alone, input changes on that falling edge cannot disturb the value being compared.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [2:0] {
    PH_ARROW_GO   = 3'd0,
    PH_ARROW_WARN = 3'd1,
    PH_A_GO       = 3'd2,
    PH_A_WARN     = 3'd3,
    PH_B_GO       = 3'd4,
    PH_B_WARN     = 3'd5,
    PH_C_GO       = 3'd6,
    PH_C_WARN     = 3'd7
  } phase_t;

  typedef struct packed {
    logic grn;
    logic yel;
    logic red;
  } lamp_t;

  localparam lamp_t LAMP_GO   = '{grn: 1'b1, yel: 1'b0, red: 1'b0};
  localparam lamp_t LAMP_WARN = '{grn: 1'b0, yel: 1'b1, red: 1'b0};
  localparam lamp_t LAMP_STOP = '{grn: 1'b0, yel: 1'b0, red: 1'b1};

  function automatic lamp_t lamp_of(input logic go, input logic warn);
    if (go)        return LAMP_GO;
    else if (warn) return LAMP_WARN;
    else           return LAMP_STOP;
  endfunction

endpackage

// File: rtl/tws_phase_seq.sv
module tws_phase_seq
  import tws_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   car_wait,
  input  logic   tmr_long,
  input  logic   tmr_short,
  output phase_t phase,
  output logic   restart
);

  phase_t phase_q, phase_d;
  logic   restart_q;
  logic   adv;

  // next-phase selection
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_ARROW_GO:   if (tmr_short) phase_d = PH_ARROW_WARN;
      PH_ARROW_WARN: if (tmr_short) phase_d = PH_A_GO;
      PH_A_GO:       if (tmr_long)  phase_d = PH_A_WARN;
      PH_A_WARN:     if (tmr_short) phase_d = PH_B_GO;
      PH_B_GO:       if (tmr_long)  phase_d = PH_B_WARN;
      PH_B_WARN:     if (tmr_short) phase_d = car_wait ? PH_C_GO : PH_ARROW_GO;
      PH_C_GO:       if (!car_wait || tmr_long) phase_d = PH_C_WARN;
      PH_C_WARN:     if (tmr_short) phase_d = PH_ARROW_GO;
      default:       phase_d = PH_ARROW_GO;
    endcase
  end

  assign adv = (phase_d != phase_q);

  // phase register with written-out enable, restart strobe beside it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_ARROW_GO;
      restart_q <= 1'b1;
    end else begin
      if (adv) phase_q <= phase_d;
      restart_q <= adv;
    end
  end

  assign phase   = phase_q;
  assign restart = restart_q;

  assert_short_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_ARROW_GO || phase_q == PH_ARROW_WARN || phase_q == PH_A_WARN ||
      phase_q == PH_B_WARN || phase_q == PH_C_WARN) && !tmr_short) |=> $stable(phase_q));

  assert_long_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_A_GO || phase_q == PH_B_GO) && !tmr_long) |=> $stable(phase_q));

  assert_c_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_C_GO && (!car_wait || tmr_long)) |=> (phase_q == PH_C_WARN));

  assert_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_A_WARN && tmr_short) |=> (phase_q == PH_B_GO));

  assert_restart_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q)) |-> restart_q);

endmodule

// File: rtl/tws_lamp_decode.sv
module tws_lamp_decode
  import tws_pkg::*;
(
  input  phase_t phase,
  output lamp_t  a_north,
  output logic   arrow_go,
  output logic   arrow_warn,
  output lamp_t  a_south,
  output lamp_t  b_east,
  output lamp_t  b_west,
  output lamp_t  c_se
);

  logic in_arrow, a_go, a_warn, b_go, b_warn, c_go, c_warn;

  always_comb begin
    in_arrow   = (phase == PH_ARROW_GO) || (phase == PH_ARROW_WARN);
    arrow_go   = (phase == PH_ARROW_GO);
    arrow_warn = (phase == PH_ARROW_WARN);
    a_go       = (phase == PH_A_GO);
    a_warn     = (phase == PH_A_WARN);
    b_go       = (phase == PH_B_GO);
    b_warn     = (phase == PH_B_WARN);
    c_go       = (phase == PH_C_GO);
    c_warn     = (phase == PH_C_WARN);

    a_north = lamp_of(in_arrow || a_go, a_warn);
    a_south = lamp_of(a_go, a_warn);
    b_east  = lamp_of(b_go, b_warn);
    b_west  = lamp_of(b_go, b_warn);
    c_se    = lamp_of(c_go, c_warn);
  end

endmodule

// File: rtl/tri_way_signal_ctrl.sv
module tri_way_signal_ctrl
  import tws_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic car_wait,
  input  logic tmr_long,
  input  logic tmr_short,
  output logic tmr_restart,
  output logic an_grn,
  output logic an_yel,
  output logic an_red,
  output logic arw_grn,
  output logic arw_yel,
  output logic arw_off,
  output logic as_grn,
  output logic as_yel,
  output logic as_red,
  output logic be_grn,
  output logic be_yel,
  output logic be_red,
  output logic bw_grn,
  output logic bw_yel,
  output logic bw_red,
  output logic c_grn,
  output logic c_yel,
  output logic c_red
);

  phase_t phase;
  lamp_t  l_an, l_as, l_be, l_bw, l_c;
  logic   arrow_go, arrow_warn;

  tws_phase_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .car_wait  (car_wait),
    .tmr_long  (tmr_long),
    .tmr_short (tmr_short),
    .phase     (phase),
    .restart   (tmr_restart)
  );

  tws_lamp_decode u_dec (
    .phase      (phase),
    .a_north    (l_an),
    .arrow_go   (arrow_go),
    .arrow_warn (arrow_warn),
    .a_south    (l_as),
    .b_east     (l_be),
    .b_west     (l_bw),
    .c_se       (l_c)
  );

  assign {an_grn, an_yel, an_red} = l_an;
  assign {as_grn, as_yel, as_red} = l_as;
  assign {be_grn, be_yel, be_red} = l_be;
  assign {bw_grn, bw_yel, bw_red} = l_bw;
  assign {c_grn,  c_yel,  c_red}  = l_c;
  assign arw_grn = arrow_go;
  assign arw_yel = arrow_warn;
  assign arw_off = !(arrow_go || arrow_warn);

  assert_heads_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({an_grn, an_yel, an_red}) == 1) && ($countones({as_grn, as_yel, as_red}) == 1) &&
    ($countones({be_grn, be_yel, be_red}) == 1) && ($countones({bw_grn, bw_yel, bw_red}) == 1) &&
    ($countones({c_grn, c_yel, c_red}) == 1) && ($countones({arw_grn, arw_yel, arw_off}) == 1));

  assert_arrow_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !arw_off |-> (an_grn && as_red && be_red && bw_red && c_red));

  assert_one_group_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!(an_red && as_red && arw_off), !(be_red && bw_red), !c_red}));

endmodule

// File: tb/tri_way_signal_ctrl_bench.sv
module tri_way_signal_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car_wait = 1'b0, tmr_long = 1'b0, tmr_short = 1'b0;
  logic tmr_restart;
  logic an_grn, an_yel, an_red, arw_grn, arw_yel, arw_off;
  logic as_grn, as_yel, as_red, be_grn, be_yel, be_red;
  logic bw_grn, bw_yel, bw_red, c_grn, c_yel, c_red;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int ref_ph = 0;

  logic [18:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  tri_way_signal_ctrl u_tri_way_signal_ctrl (.*);

  wire [18:0] act = {an_grn, an_yel, an_red, arw_grn, arw_yel, arw_off,
                     as_grn, as_yel, as_red, be_grn, be_yel, be_red,
                     bw_grn, bw_yel, bw_red, c_grn, c_yel, c_red, tmr_restart};

  // phases: 0 arrow G, 1 arrow Y, 2 A G, 3 A Y, 4 B G, 5 B Y, 6 C G, 7 C Y
  function automatic logic [18:0] expect_vec(input int p, input logic rs);
    logic [2:0] g = 3'b100, y = 3'b010, r = 3'b001;
    case (p)
      0: return {g, g, r, r, r, r, rs};
      1: return {g, y, r, r, r, r, rs};
      2: return {g, r, g, r, r, r, rs};
      3: return {y, r, y, r, r, r, rs};
      4: return {r, r, r, g, g, r, rs};
      5: return {r, r, r, y, y, r, rs};
      6: return {r, r, r, r, r, g, rs};
      default: return {r, r, r, r, r, y, rs};
    endcase
  endfunction

  function automatic int ref_next(input int p, input logic l, input logic s, input logic c);
    case (p)
      0: return s ? 1 : 0;
      1: return s ? 2 : 1;
      2: return l ? 3 : 2;
      3: return s ? 4 : 3;
      4: return l ? 5 : 4;
      5: return s ? (c ? 6 : 0) : 5;
      6: return (!c || l) ? 7 : 6;
      default: return s ? 0 : 7;
    endcase
  endfunction

  task automatic step(input logic l, input logic s, input logic c, input string tag);
    int nx;
    @(negedge clk);
    tmr_long = l; tmr_short = s; car_wait = c;
    nx = ref_next(ref_ph, l, s, c);
    @(posedge clk);
    #1;
    exp_q.push_back(expect_vec(nx, nx != ref_ph));
    tag_q.push_back(tag);
    ref_ph = nx;
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [18:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (act !== e) begin
        bad++;
        $display("FAIL %s actual=%b expected=%b", t, act, e);
      end
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    total++;
    if (act !== expect_vec(0, 1'b1)) begin
      bad++;
      $display("FAIL R1 in reset actual=%b expected=%b", act, expect_vec(0, 1'b1));
    end
    rst_n = 1'b1;
    step(0, 0, 0, "R1 hold after release");
    step(1, 0, 1, "R5 long ignored in arrow green");
    step(0, 1, 0, "R3 arrow green to arrow yellow");
    step(0, 0, 0, "R9 strobe drops");
    step(1, 0, 0, "R5 long ignored in arrow yellow");
    step(0, 1, 0, "R4 arrow yellow to A green");
    step(0, 1, 1, "R6 short ignored in A green");
    step(0, 0, 1, "R7 sensor ignored in A green");
    step(1, 0, 0, "R3 A green to A yellow");
    step(1, 0, 0, "R5 long ignored in A yellow");
    step(0, 1, 0, "R3 A yellow to B green");
    step(0, 1, 0, "R6 short ignored in B green");
    step(1, 0, 0, "R3 B green to B yellow");
    step(1, 0, 1, "R5 long ignored in B yellow");
    step(0, 1, 0, "R7 no car skips C");
    // second cycle, car served, cut by sensor drop
    step(0, 1, 0, "R3 arrow green to yellow");
    step(0, 1, 0, "R3 to A green");
    step(1, 0, 0, "R3 to A yellow");
    step(0, 1, 0, "R3 to B green");
    step(1, 0, 0, "R3 to B yellow");
    step(0, 1, 1, "R7 car enters C green");
    step(0, 1, 1, "R8 C green held by sensor");
    step(0, 0, 1, "R8 C green held");
    step(0, 0, 0, "R8 sensor drop to C yellow");
    step(1, 0, 0, "R5 long ignored in C yellow");
    step(0, 1, 1, "R8 C yellow to arrow green");
    // third cycle, C capped by long interval
    step(0, 1, 1, "R7 sensor ignored in arrow");
    step(0, 1, 1, "R3 to A green");
    step(1, 0, 1, "R3 to A yellow");
    step(0, 1, 1, "R3 to B green");
    step(1, 0, 1, "R3 to B yellow");
    step(0, 1, 1, "R7 car enters C green");
    step(1, 0, 1, "R8 long caps C green");
    step(0, 1, 1, "R8 back to arrow green");
    step(0, 0, 0, "R9 no strobe while holding");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule